// File: doc/BRIEF.md
# Two-Wire Converter Result Reader

This block is the host side of a link to a delta-sigma converter that has only two signals: a serial clock driven by the host, and one line from the converter that first marks a finished conversion (by going low) and then carries the result bits. The reader watches that line and starts a read when it sees it low. It then drives a serial clock whose phases are derived from the system clock by a divider, and shifts in the result, most significant bit first. The word is presented on a parallel bus with a one-cycle valid strobe. The result is two's complement and is passed through unchanged.

The converter is controlled only through the number of clock pulses in a frame and the level at which the clock is left. A 2-bit tail mode is sampled when each read starts. END gives one extra pulse, which returns the line high. CAL gives two extra pulses, which start a self-calibration. SLEEP parks the clock high straight after the frame. SLEEP_CAL gives two extra pulses and holds the last one high, so the converter calibrates on wake. A parked clock is released by a wake strobe. After a calibration or a wake, a watchdog counter reports a timeout if the line does not fall in time.

States: WAIT (clock low, watching the line), HIGH (clock high phase), LOW (clock low phase), PARK (clock held high, converter asleep). Transitions: WAIT→HIGH when the synchronised line is low. HIGH→LOW at the end of a high phase. HIGH→PARK at the end of the last high phase in a sleep mode. LOW→HIGH at the end of a low phase while pulses remain. LOW→WAIT at the end of the final low phase. PARK→WAIT on the wake strobe.

Top module: `adc2w_host`

## Requirements
- R1: After reset, the serial clock, valid and timeout outputs are all low.
- R2: While a frame runs, every high and every low phase of the serial clock lasts exactly HALF_DIV system clock cycles.
- R3: No serial clock pulse is issued while the synchronised data line is high in WAIT; a frame starts only after the line is seen low.
- R4: The line is sampled in the last cycle of each high phase. The first DATA_W samples form the result, first bit as the MSB. The result appears on the data output with a one-cycle valid pulse and holds until the next frame starts shifting; two's complement values are passed unchanged.
- R5: Tail mode END (code 2'd0) issues FRAME_W+1 pulses, then returns to WAIT with the clock low.
- R6: Tail mode CAL (code 2'd1) issues FRAME_W+2 pulses, then returns to WAIT with the timeout watch armed.
- R7: Tail mode SLEEP (code 2'd2) issues FRAME_W pulses and then holds the clock high until the wake strobe. The wake strobe drives the clock low and arms the timeout watch.
- R8: Tail mode SLEEP_CAL (code 2'd3) issues FRAME_W+1 full pulses, then raises the clock a final time and holds it high until the wake strobe.
- R9: When armed, the watch pulses the timeout output once for one cycle after TIMEOUT_CYC cycles in WAIT without the line going low, then disarms. It is never armed after an END frame.
- R10: The tail mode input is sampled only when a frame starts; changes during a frame have no effect on its pulse count.
- R11: The wake strobe has no effect outside PARK: the clock stays low and no timeout is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy_dout_i | input | 1 | Combined ready/data line from the converter |
| mode_i | input | 2 | Tail mode for the next frame (0 END, 1 CAL, 2 SLEEP, 3 SLEEP_CAL) |
| wake_i | input | 1 | Wake strobe, releases a parked clock |
| sclk_o | output | 1 | Serial clock to the converter |
| valid_o | output | 1 | One-cycle strobe: result complete |
| data_o | output | DATA_W | Received result, two's complement |
| timeout_o | output | 1 | One-cycle strobe: line did not fall after calibration or wake |

## Verification
The assertions check on every cycle that clock phases inside a frame are never shorter than the divider. They also check that no pulse starts while the line is high, that a parked clock stays high until the wake strobe and drops after it, that valid follows a high phase, and that the timeout strobe lasts one cycle and fires only in WAIT. Only the bench's scenarios can show the end-to-end behaviour. This covers the exact pulse count of each tail mode, that the received words equal what the converter model sent (negative values included), that a mode change in the middle of a frame is ignored, and that a timeout fires after calibration or wake when the converter stays silent but never after an END frame.

// File: rtl/adc2w_pkg.sv
package adc2w_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_PARK = 2'd3
    } rd_state_e;

    typedef enum logic [1:0] {
        TAIL_END       = 2'd0,
        TAIL_CAL       = 2'd1,
        TAIL_SLEEP     = 2'd2,
        TAIL_SLEEP_CAL = 2'd3
    } tail_mode_e;

endpackage

// File: rtl/adc2w_sync.sv
module adc2w_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc2w_halfper.sv
module adc2w_halfper #(
    parameter int HALF_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int DIV_W = $clog2(HALF_DIV + 1);

    logic [DIV_W-1:0] cnt_q;

    assign done_o = run_i && (cnt_q == DIV_W'(HALF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!run_i || done_o) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DIV_W'(HALF_DIV - 1));
endmodule

// File: rtl/adc2w_shift.sv
module adc2w_shift #(
    parameter int WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] word_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_o <= '0;
        else if (shift_i) word_o <= {word_o[WIDTH-2:0], bit_i};
    end
endmodule

// File: rtl/adc2w_watch.sv
module adc2w_watch #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic clear_i,
    input  logic count_i,
    output logic expired_o
);
    localparam int TO_W = $clog2(LIMIT + 1);

    logic            armed_q;
    logic [TO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            cnt_q     <= '0;
            expired_o <= 1'b0;
        end else begin
            expired_o <= 1'b0;
            if (clear_i) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else if (arm_i) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (armed_q && count_i) begin
                if (cnt_q == TO_W'(LIMIT - 1)) begin
                    armed_q   <= 1'b0;
                    expired_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assert_expire_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |=> !expired_o);
endmodule

// File: rtl/adc2w_host.sv
module adc2w_host
    import adc2w_pkg::*;
#(
    parameter int DATA_W      = 20,
    parameter int FRAME_W     = 24,
    parameter int HALF_DIV    = 10,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rdy_dout_i,
    input  logic [1:0]        mode_i,
    input  logic              wake_i,
    output logic              sclk_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              timeout_o
);
    localparam int CNT_W = $clog2(FRAME_W + 3);
    localparam int LEN_W = $clog2(HALF_DIV + 1);

    rd_state_e  state_q, state_d;
    tail_mode_e mode_q;
    logic [CNT_W-1:0] pcnt_q;
    logic [CNT_W-1:0] last_pulse;
    logic rdy_s, ph_done, ph_run;
    logic start, rise_end, low_end, frame_done, last_rise, park_mode, arm;
    logic sclk_q, valid_q;

    adc2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(rdy_dout_i), .q_o(rdy_s)
    );

    assign ph_run = (state_q == ST_HIGH) || (state_q == ST_LOW);

    adc2w_halfper #(.HALF_DIV(HALF_DIV)) u_half (
        .clk(clk), .rst_n(rst_n), .run_i(ph_run), .done_o(ph_done)
    );

    always_comb begin
        unique case (mode_q)
            TAIL_END:       last_pulse = CNT_W'(FRAME_W + 1);
            TAIL_CAL:       last_pulse = CNT_W'(FRAME_W + 2);
            TAIL_SLEEP:     last_pulse = CNT_W'(FRAME_W);
            TAIL_SLEEP_CAL: last_pulse = CNT_W'(FRAME_W + 2);
        endcase
    end

    assign park_mode  = mode_q[1];
    assign start      = (state_q == ST_WAIT) && !rdy_s;
    assign rise_end   = (state_q == ST_HIGH) && ph_done;
    assign low_end    = (state_q == ST_LOW) && ph_done;
    assign last_rise  = (pcnt_q + 1'b1) == last_pulse;
    assign frame_done = low_end && (pcnt_q == last_pulse);
    assign arm        = (frame_done && (mode_q == TAIL_CAL)) ||
                        ((state_q == ST_PARK) && wake_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (!rdy_s)  state_d = ST_HIGH;
            ST_HIGH: if (ph_done) state_d = (last_rise && park_mode) ? ST_PARK : ST_LOW;
            ST_LOW:  if (ph_done) state_d = (pcnt_q == last_pulse) ? ST_WAIT : ST_HIGH;
            ST_PARK: if (wake_i)  state_d = ST_WAIT;
        endcase
    end

    // outputs and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            valid_q <= 1'b0;
            pcnt_q  <= '0;
            mode_q  <= TAIL_END;
        end else begin
            sclk_q  <= (state_d == ST_HIGH) || (state_d == ST_PARK);
            valid_q <= rise_end && (pcnt_q == CNT_W'(DATA_W - 1));
            if (start) begin
                pcnt_q <= '0;
                mode_q <= tail_mode_e'(mode_i);
            end else if (rise_end) begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    adc2w_shift #(.WIDTH(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .shift_i(rise_end && (pcnt_q < CNT_W'(DATA_W))),
        .bit_i(rdy_s), .word_o(data_o)
    );

    adc2w_watch #(.LIMIT(TIMEOUT_CYC)) u_watch (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .clear_i(start),
        .count_i(state_q == ST_WAIT), .expired_o(timeout_o)
    );

    assign sclk_o  = sclk_q;
    assign valid_o = valid_q;

    // phase-length tracker for checking
    logic [LEN_W-1:0] run_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        run_len_q <= '0;
        else if (sclk_q != (state_d == ST_HIGH || state_d == ST_PARK)) run_len_q <= '0;
        else if (run_len_q != LEN_W'(HALF_DIV)) run_len_q <= run_len_q + 1'b1;
    end

    assert_high_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> $past(run_len_q) >= LEN_W'(HALF_DIV - 1));
    assert_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk_o) && $past(state_q) == ST_LOW) |-> $past(run_len_q) >= LEN_W'(HALF_DIV - 1));
    assert_start_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && rdy_s) |=> !sclk_o);
    assert_valid_after_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(state_q) == ST_HIGH);
    assert_park_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK && !wake_i) |=> sclk_o);
    assert_wake_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK && wake_i) |=> !sclk_o);
    assert_timeout_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> $past(state_q) == ST_WAIT);
    assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WAIT) |=> $stable(mode_q));
endmodule

// File: tb/adc2w_host_tb_top.sv
module adc2w_host_tb_top;
    localparam int DATA_W   = 20;
    localparam int FRAME_W  = 24;
    localparam int HALF_DIV = 10;
    localparam int TO_CYC   = 3000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic line = 1'b1;
    logic [1:0] mode = 2'd0;
    logic wake = 1'b0;
    logic sclk, valid, tmo;
    logic [DATA_W-1:0] data;

    adc2w_host #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV),
                 .SYNC_STAGES(2), .TIMEOUT_CYC(TO_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .rdy_dout_i(line), .mode_i(mode), .wake_i(wake),
        .sclk_o(sclk), .valid_o(valid), .data_o(data), .timeout_o(tmo)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // converter model: updates the line 20 ns after each rising clock edge
    int rise_cnt = 0;
    logic [DATA_W-1:0] m_word = '0;
    always @(posedge sclk) begin
        rise_cnt = rise_cnt + 1;
        #20;
        if (rise_cnt <= DATA_W)       line = m_word[DATA_W - rise_cnt];
        else if (rise_cnt <= FRAME_W) line = 1'b0;
        else                          line = 1'b1;
    end

    task automatic present(input logic [DATA_W-1:0] w);
        rise_cnt = 0;
        m_word = w;
        line = 1'b0;
    endtask

    // observers
    int vcount = 0, tcount = 0;
    int run = 0, min_high = 1000000, min_low = 1000000;
    bit seen_edge = 0;
    logic prev_sclk = 1'b0;
    always @(negedge clk) begin
        if (valid) vcount++;
        if (tmo) tcount++;
        if (sclk != prev_sclk) begin
            if (seen_edge) begin
                if (prev_sclk && run < min_high) min_high = run;
                if (!prev_sclk && run < min_low) min_low = run;
            end
            seen_edge = 1;
            run = 1;
        end else begin
            run++;
        end
        prev_sclk = sclk;
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [1:0] md, input logic [DATA_W-1:0] w,
                           input int exp_rises, input string req);
        int v0;
        v0 = vcount;
        mode = md;
        present(w);
        for (int i = 0; i < 3000 && vcount == v0; i++) @(negedge clk);
        chk(vcount == v0 + 1, "R4", "valid pulse count", vcount - v0, 1);
        wait_cycles(200);
        chk(data == w, "R4", "received word", data, w);
        chk(rise_cnt == exp_rises, req, "pulses in frame", rise_cnt, exp_rises);
    endtask

    task automatic t_reset_r1();
        wait_cycles(3);
        chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
        chk(valid == 1'b0, "R1", "valid in reset", valid, 0);
        chk(tmo == 1'b0, "R1", "timeout in reset", tmo, 0);
        rst_n = 1'b1;
        wait_cycles(300);
        chk(rise_cnt == 0, "R3", "no pulses while line high", rise_cnt, 0);
        chk(sclk == 1'b0, "R1", "sclk idle after reset", sclk, 0);
    endtask

    task automatic t_end_frames_r5();
        do_read(2'd0, 20'h7FFFF, FRAME_W + 1, "R5");
        do_read(2'd0, 20'h80001, FRAME_W + 1, "R5");
        do_read(2'd0, 20'hA5C3E, FRAME_W + 1, "R5");
        chk(sclk == 1'b0, "R5", "clock low after END frame", sclk, 0);
    endtask

    task automatic t_wake_ignored_r11();
        int t0;
        t0 = tcount;
        @(negedge clk) wake = 1'b1;
        @(negedge clk) wake = 1'b0;
        wait_cycles(50);
        chk(sclk == 1'b0, "R11", "clock after stray wake", sclk, 0);
        wait_cycles(TO_CYC + 500);
        chk(tcount == t0, "R9", "no timeout after END frame / stray wake (R11)", tcount - t0, 0);
    endtask

    task automatic t_mode_change_r10();
        int v0;
        v0 = vcount;
        mode = 2'd0;
        present(20'h12345);
        wait_cycles(60);
        mode = 2'd1;
        for (int i = 0; i < 3000 && vcount == v0; i++) @(negedge clk);
        wait_cycles(200);
        chk(rise_cnt == FRAME_W + 1, "R10", "pulses after mid-frame mode change", rise_cnt, FRAME_W + 1);
        chk(data == 20'h12345, "R4", "word with mid-frame mode change", data, 20'h12345);
        mode = 2'd0;
    endtask

    task automatic t_cal_r6();
        int t0;
        t0 = tcount;
        do_read(2'd1, 20'h0F0F0, FRAME_W + 2, "R6");
        wait_cycles(500);
        do_read(2'd0, 20'hFFFFF, FRAME_W + 1, "R6");
        chk(tcount == t0, "R6", "no timeout when converter answers", tcount - t0, 0);
    endtask

    task automatic t_cal_timeout_r9();
        int t0;
        t0 = tcount;
        do_read(2'd1, 20'h00001, FRAME_W + 2, "R6");
        wait_cycles(TO_CYC + 300);
        chk(tcount == t0 + 1, "R9", "timeout after silent calibration", tcount - t0, 1);
        wait_cycles(TO_CYC + 300);
        chk(tcount == t0 + 1, "R9", "timeout fires once", tcount - t0, 1);
        do_read(2'd0, 20'h55555, FRAME_W + 1, "R9");
    endtask

    task automatic t_sleep_r7();
        int t0;
        do_read(2'd2, 20'h3C3C3, FRAME_W, "R7");
        chk(sclk == 1'b1, "R7", "clock parked high", sclk, 1);
        wait_cycles(1000);
        chk(sclk == 1'b1 && rise_cnt == FRAME_W, "R7", "still parked, no pulses", rise_cnt, FRAME_W);
        line = 1'b1;
        t0 = tcount;
        @(negedge clk) wake = 1'b1;
        @(negedge clk) wake = 1'b0;
        wait_cycles(3);
        chk(sclk == 1'b0, "R7", "clock low after wake", sclk, 0);
        wait_cycles(TO_CYC + 300);
        chk(tcount == t0 + 1, "R7", "timeout armed by wake", tcount - t0, 1);
        do_read(2'd0, 20'h6789A, FRAME_W + 1, "R7");
    endtask

    task automatic t_sleep_cal_r8();
        int t0;
        do_read(2'd3, 20'h9ABCD, FRAME_W + 2, "R8");
        chk(sclk == 1'b1, "R8", "final pulse held high", sclk, 1);
        wait_cycles(800);
        chk(sclk == 1'b1, "R8", "held high during sleep", sclk, 1);
        t0 = tcount;
        @(negedge clk) wake = 1'b1;
        @(negedge clk) wake = 1'b0;
        wait_cycles(3);
        chk(sclk == 1'b0, "R8", "clock low after wake", sclk, 0);
        wait_cycles(300);
        do_read(2'd0, 20'h40000, FRAME_W + 1, "R8");
        chk(tcount == t0, "R8", "no timeout when converter answers", tcount - t0, 0);
    endtask

    task automatic t_phases_r2();
        chk(min_high == HALF_DIV, "R2", "shortest high phase", min_high, HALF_DIV);
        chk(min_low == HALF_DIV, "R2", "shortest low phase", min_low, HALF_DIV);
    endtask

    initial begin
        t_reset_r1();
        t_end_frames_r5();
        t_wake_ignored_r11();
        t_mode_change_r10();
        t_cal_r6();
        t_cal_timeout_r9();
        t_sleep_r7();
        t_sleep_cal_r8();
        t_phases_r2();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule